// File: doc/BRIEF.md
# Chainable Serial Gain Register

This block is a three-wire serial slave that takes volume codes for a right and a left audio channel from a host and holds them for the gain stage. The host pulls an active-low select low, clocks a frame in on the rising edges of a serial clock, and then releases select. Releasing select moves the shifted word into both channel registers in the same cycle and raises a one-cycle update strobe.

The serial output carries the old contents of the shift register out as new bits enter. The output of one device can therefore drive the data input of the next device, and a single frame of N×16 clocks loads a chain of N devices. The output is a data bit plus an enable, and the enable is high only while the device is selected. All three serial inputs are asynchronous to the system clock. They are synchronized and edge-detected inside the block, so the system clock must run at least four times faster than the serial clock.

Top module: `serial_gain_reg`

## Requirements
- R1: During and after reset, both gain outputs are code 0 (muted), the update strobe is low, the output enable is low and the shift register holds all zeros.
- R2: A 16-bit frame is taken MSB first. The first 8 bits received become the right-channel code and the last 8 bits become the left-channel code.
- R3: The gain outputs change only in a cycle where the update strobe is high. While a frame is being shifted, they keep their previous values.
- R4: Each rising edge of the synchronized select produces exactly one update strobe, and the strobe lasts one system clock cycle.
- R5: The serial output enable is high only while the synchronized select is low. It goes low within the synchronizer latency after select rises.
- R6: The serial data output presents the previous shift-register contents MSB first. The first bit appears after select falls, and each following bit appears after a falling serial clock edge. The output changes at no other time.
- R7: Serial clock edges while select is high do not shift the register. An update that follows with no clocks in between re-applies the unchanged codes.
- R8: A frame with fewer or more than 16 clocks leaves the last 16 bits received in the register. The bits that were not replaced shift toward the MSB, and the gains are taken from that register at select rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_i | input | 1 | Active-low select, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data in, sampled on serial clock rise |
| sdo_o | output | 1 | Serial data out toward the next device |
| sdo_oe_o | output | 1 | Enable for the serial data out driver |
| gain_right_o | output | CODE_W | Right-channel gain code |
| gain_left_o | output | CODE_W | Left-channel gain code |
| update_o | output | 1 | One-cycle strobe when new codes are applied |

## Verification
The bench uses the defaults CODE_W = 8 and SYNC_STAGES = 2, so one frame is 16 bits and the synchronizer delay is three system cycles. The serial clock runs at one eighth of the system clock. With a 16-bit register, the bench can follow the register bit by bit for frames of 16 clocks, 4 clocks (short), 20 clocks (long) and no clocks at all. From that trace it predicts every bit on the serial output and every pair of codes applied at select rise. The frame data includes alternating bits, all ones in one half and all zeros in the other, so crossed or misordered halves show up.

// File: rtl/gsr_pkg.sv
// Shared constants and types for the serial gain register.
// Assumes nothing beyond the synthesizable subset.
package gsr_pkg;
    localparam int LANE_CSN  = 0;
    localparam int LANE_SCLK = 1;
    localparam int LANE_SDI  = 2;
    localparam int NUM_LANES = 3;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;
endpackage

// File: rtl/gsr_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes each lane is stable for several system clocks per change.
module gsr_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // first flop captures the asynchronous lanes
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= RST_VAL;
                else        stg[s] <= d;
            end
        end else begin : g_next
            // later flops settle any metastability
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= RST_VAL;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gsr_edge.sv
// Rise/fall detector for one synchronized level.
// Assumes the input is already in the clk domain.
module gsr_edge #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           lvl,
    output gsr_pkg::edge_t ev
);
    logic prev;

    // remember last level for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= lvl;
    end

    assign ev.rise = lvl & ~prev;
    assign ev.fall = ~lvl & prev;
endmodule

// File: rtl/gsr_shift.sv
// Frame shift register with a registered chain output.
// Shifts din in at LSB on shift_en; sdo shows the MSB, refreshed on out_en.
// Assumes shift_en and out_en are never high in the same cycle.
module gsr_shift #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               out_en,
    input  logic               din,
    output logic [FRAME_W-1:0] frame_o,
    output logic               sdo_o
);
    logic [FRAME_W-1:0] sr;

    // move one bit in on each qualified serial clock rise
    always_ff @(posedge clk) begin
        if (!rst_n)        sr <= '0;
        else if (shift_en) sr <= {sr[FRAME_W-2:0], din};
    end

    // present the oldest bit after select fall or serial clock fall
    always_ff @(posedge clk) begin
        if (!rst_n)      sdo_o <= 1'b0;
        else if (out_en) sdo_o <= sr[FRAME_W-1];
    end

    assign frame_o = sr;
endmodule

// File: rtl/gsr_hold.sv
// Per-channel gain holding registers with a one-cycle update strobe.
// Channel 0 takes the first-sent (most significant) slice of the frame.
// Assumes load is a single-cycle pulse.
module gsr_hold #(
    parameter int CODE_W = 8,
    parameter int NUM_CH = 2,
    localparam int FRAME_W = CODE_W * NUM_CH
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           load,
    input  logic [FRAME_W-1:0]             frame,
    output logic [NUM_CH-1:0][CODE_W-1:0]  gains_o,
    output logic                           upd_o
);
    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        localparam int HI = FRAME_W - 1 - k * CODE_W;
        // capture this channel's slice on select release
        always_ff @(posedge clk) begin
            if (!rst_n)    gains_o[k] <= '0;
            else if (load) gains_o[k] <= frame[HI -: CODE_W];
        end
    end

    // strobe marks the cycle the new codes appear
    always_ff @(posedge clk) begin
        if (!rst_n) upd_o <= 1'b0;
        else        upd_o <= load;
    end
endmodule

// File: rtl/serial_gain_reg.sv
// Daisy-chainable serial gain register, top level.
// Synchronizes select, serial clock and data; shifts on serial clock rise
// while selected; drives chain output after falls; applies codes on select rise.
// Assumes clk is at least 4x the serial clock rate.
module serial_gain_reg #(
    parameter int CODE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic [CODE_W-1:0] gain_right_o,
    output logic [CODE_W-1:0] gain_left_o,
    output logic              update_o
);
    import gsr_pkg::*;

    localparam int NUM_CH  = 2;
    localparam int FRAME_W = NUM_CH * CODE_W;
    localparam logic [NUM_LANES-1:0] SYNC_RST = NUM_LANES'(1) << LANE_CSN;

    logic [NUM_LANES-1:0]          raw_in, syn;
    edge_t                         cs_ev, sclk_ev;
    logic                          selected;
    logic                          sclk_rise_ev, sclk_fall_ev, cs_fall_ev;
    logic [FRAME_W-1:0]            frame;
    logic [NUM_CH-1:0][CODE_W-1:0] gains;

    always_comb begin
        raw_in            = '0;
        raw_in[LANE_CSN]  = cs_n_i;
        raw_in[LANE_SCLK] = sclk_i;
        raw_in[LANE_SDI]  = sdi_i;
    end

    gsr_sync #(.W(NUM_LANES), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
    );

    gsr_edge #(.RST_VAL(1'b1)) u_cs_edge (
        .clk(clk), .rst_n(rst_n), .lvl(syn[LANE_CSN]), .ev(cs_ev)
    );

    gsr_edge #(.RST_VAL(1'b0)) u_sclk_edge (
        .clk(clk), .rst_n(rst_n), .lvl(syn[LANE_SCLK]), .ev(sclk_ev)
    );

    assign selected     = ~syn[LANE_CSN];
    assign sclk_rise_ev = sclk_ev.rise & selected;
    assign sclk_fall_ev = sclk_ev.fall & selected;
    assign cs_fall_ev   = cs_ev.fall;

    gsr_shift #(.FRAME_W(FRAME_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .shift_en(sclk_rise_ev),
        .out_en(sclk_fall_ev | cs_fall_ev),
        .din(syn[LANE_SDI]),
        .frame_o(frame),
        .sdo_o(sdo_o)
    );

    gsr_hold #(.CODE_W(CODE_W), .NUM_CH(NUM_CH)) u_hold (
        .clk(clk), .rst_n(rst_n),
        .load(cs_ev.rise),
        .frame(frame),
        .gains_o(gains),
        .upd_o(update_o)
    );

    assign sdo_oe_o     = selected;
    assign gain_right_o = gains[0];
    assign gain_left_o  = gains[1];
endmodule

// File: rtl/gsr_checker.sv
// Property checker for serial_gain_reg, attached by bind.
// Assumes synchronous active-low reset driven from time zero.
module gsr_checker #(
    parameter int CODE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n_i,
    input logic              sdo_o,
    input logic              sdo_oe_o,
    input logic [CODE_W-1:0] gain_right_o,
    input logic [CODE_W-1:0] gain_left_o,
    input logic              update_o,
    input logic              sclk_fall_ev,
    input logic              cs_fall_ev
);
    logic [3:0] hi_cnt;

    // count consecutive cycles with select released
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_n_i) hi_cnt <= '0;
        else if (hi_cnt != 4'hF) hi_cnt <= hi_cnt + 4'd1;
    end

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (gain_right_o == '0 && gain_left_o == '0 && !update_o && !sdo_oe_o));

    p_gain_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !update_o |-> ($stable(gain_right_o) && $stable(gain_left_o)));

    p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |=> !update_o);

    p_oe_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(hi_cnt) >= SYNC_STAGES) |-> !sdo_oe_o);

    p_sdo_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(sclk_fall_ev) && !$past(cs_fall_ev)) |-> $stable(sdo_o));
endmodule

bind serial_gain_reg gsr_checker #(.CODE_W(CODE_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
    .gain_right_o(gain_right_o), .gain_left_o(gain_left_o), .update_o(update_o),
    .sclk_fall_ev(sclk_fall_ev), .cs_fall_ev(cs_fall_ev)
);

// File: tb/serial_gain_reg_bench.sv
// Scoreboard bench: driver models the shift register and queues expected codes;
// monitor pops and compares on each update strobe.
module serial_gain_reg_bench;
    localparam int CODE_W = 8;
    localparam int FW     = 2 * CODE_W;
    localparam int HALF   = 4;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic sdo, sdo_oe, upd;
    logic [CODE_W-1:0] g_r, g_l;

    int checks = 0, fails = 0, pushed = 0, popped = 0;
    bit done = 1'b0;
    logic [FW-1:0] mdl = '0;
    logic [FW-1:0] last_applied = '0;
    logic [FW-1:0] expq [$];

    always #10 clk = ~clk;

    serial_gain_reg #(.CODE_W(CODE_W), .SYNC_STAGES(2)) u_serial_gain_reg (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe), .gain_right_o(g_r), .gain_left_o(g_l),
        .update_o(upd)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // drive one frame of n bits, MSB of the n-bit value first
    task automatic frame(input logic [31:0] bits, input int n);
        cs_n = 1'b0;
        wclk(HALF);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = bits[i];
            wclk(HALF);
            chk("R6 sdo bit", {31'd0, sdo}, {31'd0, mdl[FW-1]});
            chk("R5 oe while selected", {31'd0, sdo_oe}, 32'd1);
            chk("R3 gains held mid-frame", {16'd0, g_r, g_l}, {16'd0, last_applied});
            mdl = {mdl[FW-2:0], bits[i]};
            sclk = 1'b1;
            wclk(HALF);
            sclk = 1'b0;
        end
        wclk(HALF);
        expq.push_back(mdl);
        pushed++;
        last_applied = mdl;
        cs_n = 1'b1;
        wclk(10);
        chk("R5 oe off after release", {31'd0, sdo_oe}, 32'd0);
    endtask

    // monitor: compare applied codes at every strobe
    always @(negedge clk) begin
        if (rst_n && upd) begin
            popped++;
            if (expq.size() == 0) begin
                chk("R4 unexpected strobe", 32'd1, 32'd0);
            end else begin
                logic [FW-1:0] e;
                e = expq.pop_front();
                chk("R2 right code", {24'd0, g_r}, {24'd0, e[FW-1 -: CODE_W]});
                chk("R2 left code", {24'd0, g_l}, {24'd0, e[CODE_W-1:0]});
            end
        end
    end

    initial begin
        wclk(5);
        chk("R1 right reset", {24'd0, g_r}, 32'd0);
        chk("R1 left reset", {24'd0, g_l}, 32'd0);
        chk("R1 strobe reset", {31'd0, upd}, 32'd0);
        chk("R1 oe reset", {31'd0, sdo_oe}, 32'd0);
        rst_n = 1'b1;
        wclk(5);
        frame(32'hA55A, 16);   // R2, R6 shows reset zeros
        frame(32'h00FF, 16);   // R2, R6 shows A55A
        frame(32'hFF00, 16);
        frame(32'h1234, 16);
        // R7: serial clocks while deselected must not shift
        sdi = 1'b1;
        for (int k = 0; k < 5; k++) begin
            sclk = 1'b1; wclk(HALF);
            sclk = 1'b0; wclk(HALF);
            chk("R7 oe off while idle clocks", {31'd0, sdo_oe}, 32'd0);
        end
        frame(32'h0, 0);       // R7 empty frame re-applies 1234
        frame(32'hB, 4);       // R8 short frame
        frame(32'hABCDE, 20);  // R8 long frame
        frame(32'h8001, 16);   // R6 shows leftover of long frame
        wclk(20);
        chk("R4 strobe count", popped, pushed);
        chk("R4 queue drained", expq.size(), 32'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule